// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block carries out the memory traffic and register update that a 32-bit core needs to take an exception or interrupt and later return from it. On an entry request it fetches a two-word descriptor (handler instruction pointer, then handler stack pointer) from a vector table. It moves to the handler stack and stores the interrupted context there one word per cycle: old stack pointer, flags, return address and old frame pointer. Up to two argument words follow. At the end it writes the new IP, SP, FP and FLAGS in a single cycle. A return request pops the frame and restores the four registers.

The memory port carries one 32-bit access per cycle. The response (`mem_rdata`, `mem_fault`) is taken combinationally in the same cycle as the request. A fault or an out-of-range index during entry restarts the entry once on the double-fault vector, with the original index as the only argument. A second failure, or any fault while returning, stops the block in a sticky halted state. Architectural registers are only written at the very end of a successful sequence, so a failed attempt leaves them as they were.

Top module: `exc_seq`

## Requirements
- R1: Descriptor words are read at VT_BASE + 8*index: the handler IP at offset 0 in one cycle, then the handler SP at offset 4 in the next cycle.
- R2: An index at or above NUM_EXC issues no memory access in its descriptor cycle and counts as an entry fault.
- R3: After the descriptor, the context is written to the handler stack in this order: old SP, FLAGS (bits 31:6 zero), return IP (the IP input at the request), old FP. Then arg0 and arg1 are written, as many as the argument count (0 to 2; a count of 3 is treated as 2).
- R4: Every push first lowers the working SP by 4 modulo 2^32 and then writes at the new value, so consecutive pushes descend by 4 and wrap below address 0.
- R5: A successful entry ends with one update cycle (`reg_wr_en` high) that writes IP = handler IP, SP = final stack pointer, FP = the SP after the old-FP push, and FLAGS = saved flags with bit 0 (privileged) set and bit 1 (interrupt enable) cleared.
- R6: A return reads FP, IP, FLAGS and SP in that order from the current SP upward in steps of 4. It then writes all four in one update cycle, FLAGS masked to bits 5:0. Arguments are not skipped: the return starts at the SP it is given.
- R7: FLAGS bit positions: 0 privileged, 1 hardware interrupt enable, 2 equal, 3 zero, 4 overflow, 5 sign. All other bits are written as zero.
- R8: A fault on any entry access, or an invalid index, restarts entry with DF_IDX and a single argument holding the original index zero-extended. The saved context is still the original register values.
- R9: A fault during the double-fault entry, or during any return access, raises `halted` with no register update. While halted there are no memory accesses and all requests are ignored until reset.
- R10: `busy` is high from the cycle after a request is accepted through the update cycle, and low in the cycle after it.
- R11: Requests that arrive while busy are ignored. If entry and return are requested together while idle, entry wins.
- R12: After reset: `busy`, `halted`, `mem_req` and `reg_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Start an exception entry |
| entry_idx | input | IDX_W | Exception index |
| entry_argc | input | 2 | Number of argument words |
| entry_arg0 | input | 32 | First argument word |
| entry_arg1 | input | 32 | Second argument word |
| ret_req | input | 1 | Start a return |
| busy | output | 1 | Sequence in progress |
| halted | output | 1 | Sticky stop after an unrecoverable fault |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |
| mem_fault | input | 1 | Access faulted, same cycle |
| reg_ip_i | input | 32 | Current IP |
| reg_sp_i | input | 32 | Current SP |
| reg_fp_i | input | 32 | Current FP |
| reg_flags_i | input | 32 | Current FLAGS |
| reg_wr_en | output | 1 | Write all four registers this cycle |
| reg_ip_o | output | 32 | New IP |
| reg_sp_o | output | 32 | New SP |
| reg_fp_o | output | 32 | New FP |
| reg_flags_o | output | 32 | New FLAGS |

## Verification
The bench builds the block with NUM_EXC = 12, IDX_W = 6, DF_IDX = 3 and VT_BASE = 0x40. The small table puts the out-of-range boundary (index 11 against 12) within easy reach. The non-zero base exposes any descriptor address that ignores it, and the double-fault vector is a normal table slot that can be made to fault on its own. One vector has a handler SP of zero, which drives the pushes through the 2^32 wrap.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int FLG_W    = 6;
    localparam int PRIV_BIT = 0;
    localparam int HWI_BIT  = 1;
    localparam int CTX_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_VIP   = 3'd1,
        ST_VSP   = 3'd2,
        ST_PUSH  = 3'd3,
        ST_ARG   = 3'd4,
        ST_EDONE = 3'd5,
        ST_POP   = 3'd6,
        ST_RDONE = 3'd7
    } seq_state_e;

endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
    parameter int          IDX_W   = 8,
    parameter int          NUM_EXC = 32,
    parameter logic [31:0] VT_BASE = 32'h0
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             hi_i,
    output logic [31:0]      addr_o,
    output logic             ok_o
);
    localparam logic [31:0] NUM_L = 32'(NUM_EXC);

    logic [31:0] idx_ext;
    assign idx_ext = {{(32-IDX_W){1'b0}}, idx_i};
    assign addr_o  = VT_BASE + (idx_ext << 3) + (hi_i ? 32'd4 : 32'd0);
    assign ok_o    = (idx_ext < NUM_L);
endmodule

// File: rtl/exc_sp_step.sv
module exc_sp_step (
    input  logic [31:0] sp_i,
    output logic [31:0] sp_dn_o,
    output logic [31:0] sp_up_o
);
    assign sp_dn_o = sp_i - 32'd4;
    assign sp_up_o = sp_i + 32'd4;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int          IDX_W   = 8,
    parameter int          NUM_EXC = 32,
    parameter int          DF_IDX  = 8,
    parameter logic [31:0] VT_BASE = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_req,
    input  logic [IDX_W-1:0] entry_idx,
    input  logic [1:0]       entry_argc,
    input  logic [31:0]      entry_arg0,
    input  logic [31:0]      entry_arg1,
    input  logic             ret_req,
    output logic             busy,
    output logic             halted,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_fault,
    input  logic [31:0]      reg_ip_i,
    input  logic [31:0]      reg_sp_i,
    input  logic [31:0]      reg_fp_i,
    input  logic [31:0]      reg_flags_i,
    output logic             reg_wr_en,
    output logic [31:0]      reg_ip_o,
    output logic [31:0]      reg_sp_o,
    output logic [31:0]      reg_fp_o,
    output logic [31:0]      reg_flags_o
);
    localparam logic [IDX_W-1:0] DF_I      = IDX_W'(DF_IDX);
    localparam logic [1:0]       LAST_CTX  = 2'(CTX_WORDS - 1);
    localparam logic [FLG_W-1:0] PRIV_MASK = FLG_W'(1) << PRIV_BIT;
    localparam logic [FLG_W-1:0] HWI_MASK  = FLG_W'(1) << HWI_BIT;

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       step;
        logic             lvl;
        logic             halted;
        logic [IDX_W-1:0] idx;
        logic [1:0]       argc;
        logic [31:0]      arg0;
        logic [31:0]      arg1;
        logic [31:0]      ret_ip;
        logic [31:0]      old_sp;
        logic [31:0]      old_fp;
        logic [FLG_W-1:0] flags;
        logic [31:0]      vip;
        logic [31:0]      sp;
        logic [31:0]      fp;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [31:0] vec_addr, sp_dn, sp_up, ctx_word;
    logic        vec_ok, fail;
    logic        unused_hi;

    assign unused_hi = ^reg_flags_i[31:FLG_W];

    exc_vec_addr #(.IDX_W(IDX_W), .NUM_EXC(NUM_EXC), .VT_BASE(VT_BASE)) vec_i (
        .idx_i  (seq_q.idx),
        .hi_i   (seq_q.st == ST_VSP),
        .addr_o (vec_addr),
        .ok_o   (vec_ok)
    );

    exc_sp_step step_i (
        .sp_i    (seq_q.sp),
        .sp_dn_o (sp_dn),
        .sp_up_o (sp_up)
    );

    always_comb begin
        case (seq_q.step)
            2'd0:    ctx_word = seq_q.old_sp;
            2'd1:    ctx_word = 32'(seq_q.flags);
            2'd2:    ctx_word = seq_q.ret_ip;
            default: ctx_word = seq_q.old_fp;
        endcase
    end

    always_comb begin
        seq_d     = seq_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'h0;
        mem_wdata = 32'h0;
        fail      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (!seq_q.halted && entry_req) begin
                    seq_d.st     = ST_VIP;
                    seq_d.step   = 2'd0;
                    seq_d.lvl    = 1'b0;
                    seq_d.idx    = entry_idx;
                    seq_d.argc   = (entry_argc == 2'd3) ? 2'd2 : entry_argc;
                    seq_d.arg0   = entry_arg0;
                    seq_d.arg1   = entry_arg1;
                    seq_d.ret_ip = reg_ip_i;
                    seq_d.old_sp = reg_sp_i;
                    seq_d.old_fp = reg_fp_i;
                    seq_d.flags  = reg_flags_i[FLG_W-1:0];
                end else if (!seq_q.halted && ret_req) begin
                    seq_d.st   = ST_POP;
                    seq_d.step = 2'd0;
                    seq_d.sp   = reg_sp_i;
                end
            end
            ST_VIP: begin
                if (!vec_ok) begin
                    fail = 1'b1;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = vec_addr;
                    if (mem_fault) fail = 1'b1;
                    else begin
                        seq_d.vip = mem_rdata;
                        seq_d.st  = ST_VSP;
                    end
                end
            end
            ST_VSP: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
                if (mem_fault) fail = 1'b1;
                else begin
                    seq_d.sp   = mem_rdata;
                    seq_d.st   = ST_PUSH;
                    seq_d.step = 2'd0;
                end
            end
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = ctx_word;
                if (mem_fault) fail = 1'b1;
                else begin
                    seq_d.sp   = sp_dn;
                    seq_d.step = seq_q.step + 2'd1;
                    if (seq_q.step == LAST_CTX) begin
                        seq_d.fp   = sp_dn;
                        seq_d.step = 2'd0;
                        seq_d.st   = (seq_q.argc == 2'd0) ? ST_EDONE : ST_ARG;
                    end
                end
            end
            ST_ARG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = seq_q.step[0] ? seq_q.arg1 : seq_q.arg0;
                if (mem_fault) fail = 1'b1;
                else begin
                    seq_d.sp   = sp_dn;
                    seq_d.step = seq_q.step + 2'd1;
                    if (seq_q.step + 2'd1 == seq_q.argc) seq_d.st = ST_EDONE;
                end
            end
            ST_POP: begin
                mem_req  = 1'b1;
                mem_addr = seq_q.sp;
                if (mem_fault) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.halted = 1'b1;
                end else begin
                    seq_d.sp   = sp_up;
                    seq_d.step = seq_q.step + 2'd1;
                    case (seq_q.step)
                        2'd0:    seq_d.fp     = mem_rdata;
                        2'd1:    seq_d.vip    = mem_rdata;
                        2'd2:    seq_d.flags  = mem_rdata[FLG_W-1:0];
                        default: seq_d.old_sp = mem_rdata;
                    endcase
                    if (seq_q.step == LAST_CTX) seq_d.st = ST_RDONE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (fail) begin
            if (!seq_q.lvl) begin
                seq_d.lvl  = 1'b1;
                seq_d.idx  = DF_I;
                seq_d.argc = 2'd1;
                seq_d.arg0 = 32'(seq_q.idx);
                seq_d.st   = ST_VIP;
                seq_d.step = 2'd0;
            end else begin
                seq_d.st     = ST_IDLE;
                seq_d.halted = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy        = (seq_q.st != ST_IDLE);
    assign halted      = seq_q.halted;
    assign reg_wr_en   = (seq_q.st == ST_EDONE) || (seq_q.st == ST_RDONE);
    assign reg_ip_o    = seq_q.vip;
    assign reg_sp_o    = (seq_q.st == ST_RDONE) ? seq_q.old_sp : seq_q.sp;
    assign reg_fp_o    = seq_q.fp;
    assign reg_flags_o = (seq_q.st == ST_EDONE)
                       ? 32'((seq_q.flags | PRIV_MASK) & ~HWI_MASK)
                       : 32'(seq_q.flags);

    // consecutive pushes step down by one word
    assert_push_descend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we && !mem_fault))
        |-> (mem_addr == $past(mem_addr) - 32'd4));

    // descriptor and pop reads step up by one word (R1 as well)
    assert_read_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && !mem_we && !mem_fault))
        |-> (mem_addr == $past(mem_addr) + 32'd4));

    // an update that follows a push is an entry: privileged on, interrupts off
    assert_entry_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && $past(mem_we))
        |-> (reg_flags_o[PRIV_BIT] && !reg_flags_o[HWI_BIT]));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!busy && !mem_req && !reg_wr_en));

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !busy);

endmodule

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;
    localparam int          IDXW = 6;
    localparam int          NEXC = 12;
    localparam int          DFI  = 3;
    localparam logic [31:0] VTB  = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0, ret_req = 1'b0;
    logic [IDXW-1:0] entry_idx = '0;
    logic [1:0]  entry_argc = '0;
    logic [31:0] entry_arg0 = '0, entry_arg1 = '0;
    logic        busy, halted, mem_req, mem_we, mem_fault, reg_wr_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] reg_ip_o, reg_sp_o, reg_fp_o, reg_flags_o;
    logic [31:0] m_ip, m_sp, m_fp, m_flags;

    always #2 clk = ~clk;

    exc_seq #(.IDX_W(IDXW), .NUM_EXC(NEXC), .DF_IDX(DFI), .VT_BASE(VTB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .entry_req(entry_req), .entry_idx(entry_idx), .entry_argc(entry_argc),
        .entry_arg0(entry_arg0), .entry_arg1(entry_arg1), .ret_req(ret_req),
        .busy(busy), .halted(halted),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .reg_ip_i(m_ip), .reg_sp_i(m_sp), .reg_fp_i(m_fp), .reg_flags_i(m_flags),
        .reg_wr_en(reg_wr_en), .reg_ip_o(reg_ip_o), .reg_sp_o(reg_sp_o),
        .reg_fp_o(reg_fp_o), .reg_flags_o(reg_flags_o)
    );

    int n_checks = 0, n_fail = 0;
    bit flt_en [2];
    logic [31:0] flt_a [2];
    logic [31:0] dev_mem [0:1023];
    logic [31:0] mdl_mem [logic [31:0]];

    function automatic bit in_vt(input logic [31:0] a);
        return (a >= VTB) && (a < VTB + 32'(NEXC) * 32'd8);
    endfunction

    // table content: vector 5 has a zero stack pointer
    function automatic logic [31:0] vec_word(input logic [31:0] a);
        logic [31:0] i;
        i = (a - VTB) >> 3;
        if (!a[2]) return 32'h4000_0000 + i * 32'h10;
        return (i == 32'd5) ? 32'h0 : 32'h400 + i * 32'h20;
    endfunction

    function automatic bit m_fault(input logic [31:0] a);
        return (flt_en[0] && a == flt_a[0]) || (flt_en[1] && a == flt_a[1]);
    endfunction

    always_comb begin
        mem_fault = mem_req && m_fault(mem_addr);
        mem_rdata = in_vt(mem_addr) ? vec_word(mem_addr) : dev_mem[mem_addr[11:2]];
    end

    always_ff @(posedge clk)
        if (mem_req && mem_we && !mem_fault) dev_mem[mem_addr[11:2]] <= mem_wdata;

    function automatic logic [31:0] m_rd(input logic [31:0] a);
        if (in_vt(a)) return vec_word(a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 32'h0;
    endfunction

    typedef struct packed {
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        upd;
        logic [7:0]  tag;
    } cyc_t;

    cyc_t exp_q [$];
    bit exp_upd, exp_halt;
    logic [31:0] e_ip, e_sp, e_fp, e_flags;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void add(input bit rq, input bit w, input logic [31:0] a,
                                input logic [31:0] d, input bit u, input int tg);
        exp_q.push_back({rq, w, a, d, u, 8'(tg)});
    endfunction

    // behavioural reference for an entry; R2 invalid index, R8 escalation
    task automatic model_entry(input int idx, input int argc, input logic [31:0] a0, input logic [31:0] a1);
        int lvl, cur, n;
        logic [31:0] args [2];
        logic [31:0] ctx [6];
        logic [31:0] vip, vsp, s, nfp, a;
        bit bad, done;
        exp_q.delete();
        exp_upd = 0; exp_halt = 0; lvl = 0; cur = idx; n = (argc > 2) ? 2 : argc;
        args[0] = a0; args[1] = a1; done = 0; vip = 0; vsp = 0; nfp = 0; s = 0;
        while (!done) begin
            bad = 0;
            if (cur >= NEXC) begin
                add(0, 0, 0, 0, 0, 2);
                bad = 1;
            end else begin
                a = VTB + 32'(cur) * 32'd8;
                add(1, 0, a, 0, 0, (lvl != 0) ? 8 : 1);
                if (m_fault(a)) bad = 1;
                else begin
                    vip = m_rd(a);
                    add(1, 0, a + 32'd4, 0, 0, (lvl != 0) ? 8 : 1);
                    if (m_fault(a + 32'd4)) bad = 1;
                    else vsp = m_rd(a + 32'd4);
                end
            end
            if (!bad) begin
                ctx = '{m_sp, m_flags & 32'h3F, m_ip, m_fp, args[0], args[1]};
                s = vsp;
                for (int k = 0; k < 4 + n && !bad; k++) begin
                    s = s - 32'd4;
                    add(1, 1, s, ctx[k], 0, (lvl != 0) ? 8 : 3);
                    if (m_fault(s)) bad = 1;
                    else begin
                        mdl_mem[s] = ctx[k];
                        if (k == 3) nfp = s;
                    end
                end
            end
            if (bad) begin
                if (lvl == 0) begin
                    lvl = 1; args[0] = 32'(idx); n = 1; cur = DFI;
                end else begin
                    exp_halt = 1; done = 1;
                end
            end else begin
                add(0, 0, 0, 0, 1, 5);
                e_ip = vip; e_sp = s; e_fp = nfp;
                e_flags = ((m_flags & 32'h3F) | 32'h1) & ~32'h2;
                exp_upd = 1; done = 1;
            end
        end
    endtask

    task automatic model_ret();
        logic [31:0] s;
        logic [31:0] v [4];
        bit bad;
        exp_q.delete();
        exp_upd = 0; exp_halt = 0; s = m_sp; bad = 0;
        for (int k = 0; k < 4 && !bad; k++) begin
            add(1, 0, s, 0, 0, 6);
            if (m_fault(s)) bad = 1;
            else begin
                v[k] = m_rd(s);
                s = s + 32'd4;
            end
        end
        if (bad) exp_halt = 1;
        else begin
            add(0, 0, 0, 0, 1, 6);
            e_fp = v[0]; e_ip = v[1]; e_flags = v[2] & 32'h3F; e_sp = v[3];
            exp_upd = 1;
        end
    endtask

    task automatic play(input int poke);
        for (int k = 0; k < exp_q.size(); k++) begin
            cyc_t c;
            string tg;
            c = exp_q[k];
            tg = $sformatf("R%0d", c.tag);
            chk(busy === 1'b1, "R10 busy", 32'(busy), 32'd1);
            chk(mem_req === c.req, {tg, " req"}, 32'(mem_req), 32'(c.req));
            if (c.req) begin
                chk(mem_we === c.we, {tg, " we"}, 32'(mem_we), 32'(c.we));
                chk(mem_addr === c.addr, {tg, " addr"}, mem_addr, c.addr);
                if (c.we) chk(mem_wdata === c.wd, {tg, " wdata"}, mem_wdata, c.wd);
            end
            chk(reg_wr_en === c.upd, {tg, " update"}, 32'(reg_wr_en), 32'(c.upd));
            if (c.upd) begin
                chk(reg_ip_o === e_ip, {tg, " ip"}, reg_ip_o, e_ip);
                chk(reg_sp_o === e_sp, {tg, " sp"}, reg_sp_o, e_sp);
                chk(reg_fp_o === e_fp, {tg, " fp"}, reg_fp_o, e_fp);
                chk(reg_flags_o === e_flags, {tg, " R7 flags"}, reg_flags_o, e_flags);
            end
            if (k == poke) begin
                entry_req = 1'b1; ret_req = 1'b1; entry_idx = 6'd1;
            end
            @(negedge clk);
            entry_req = 1'b0; ret_req = 1'b0;
        end
        chk(busy === 1'b0, "R10 busy low", 32'(busy), 32'd0);
        chk(halted === exp_halt, "R9 halted", 32'(halted), 32'(exp_halt));
        chk(reg_wr_en === 1'b0, "R10 single update", 32'(reg_wr_en), 32'd0);
        if (poke >= 0) chk(mem_req === 1'b0, "R11 poke ignored", 32'(mem_req), 32'd0);
        if (exp_upd) begin
            m_ip = e_ip; m_sp = e_sp; m_fp = e_fp; m_flags = e_flags;
        end
    endtask

    task automatic do_entry(input int idx, input int argc, input logic [31:0] a0,
                            input logic [31:0] a1, input int poke, input bit with_ret);
        model_entry(idx, argc, a0, a1);
        entry_req = 1'b1; ret_req = with_ret; entry_idx = IDXW'(idx);
        entry_argc = 2'(argc); entry_arg0 = a0; entry_arg1 = a1;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        play(poke);
    endtask

    task automatic do_ret();
        model_ret();
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        play(-1);
    endtask

    task automatic handler_pops(input int n);
        m_sp = m_sp + 32'(4 * n);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; entry_req = 1'b0; ret_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_ip = 32'h0000_1000; m_sp = 32'h0000_0C00; m_fp = 32'h0000_0C40;
        m_flags = 32'hFFFF_FF0A;
        mdl_mem.delete();
        flt_en[0] = 0; flt_en[1] = 0;
        chk(busy === 1'b0, "R12 busy", 32'(busy), 32'd0);
        chk(halted === 1'b0, "R12 halted", 32'(halted), 32'd0);
        chk(mem_req === 1'b0, "R12 mem_req", 32'(mem_req), 32'd0);
        chk(reg_wr_en === 1'b0, "R12 reg_wr_en", 32'(reg_wr_en), 32'd0);
    endtask

    bit finished = 0;

    initial begin
        flt_en[0] = 0; flt_en[1] = 0; flt_a[0] = 0; flt_a[1] = 0;
        m_ip = 0; m_sp = 0; m_fp = 0; m_flags = 0;
        @(negedge clk);
        do_reset();
        // R11: entry and return together -> entry runs
        do_entry(4, 0, 0, 0, -1, 1);
        do_ret();
        // two arguments, requests poked while busy (R11)
        do_entry(7, 2, 32'hAAAA_0001, 32'hBBBB_0002, 3, 0);
        handler_pops(2);
        do_ret();
        // handler SP of zero: pushes wrap (R4), count 3 treated as 2 (R3)
        do_entry(5, 3, 32'hC0DE_0005, 32'hC0DE_0006, -1, 0);
        handler_pops(2);
        do_ret();
        // nesting
        do_entry(1, 0, 0, 0, -1, 0);
        do_entry(2, 2, 32'h1111_2222, 32'h3333_4444, -1, 0);
        handler_pops(2);
        do_ret();
        do_ret();
        // last valid index, then first invalid one (R2, R8)
        do_entry(11, 1, 32'h5555_0011, 0, -1, 0);
        handler_pops(1);
        do_ret();
        do_entry(12, 1, 32'h6666_0012, 0, -1, 0);
        handler_pops(1);
        do_ret();
        // R8: fault on the flags push of vector 9
        flt_en[0] = 1; flt_a[0] = 32'h400 + 32'd9 * 32'h20 - 32'd8;
        do_entry(9, 0, 0, 0, -1, 0);
        handler_pops(1);
        do_ret();
        // R8: fault on the descriptor SP word of vector 6
        flt_a[0] = VTB + 32'd6 * 32'd8 + 32'd4;
        do_entry(6, 2, 32'h7777_0001, 32'h7777_0002, -1, 0);
        handler_pops(1);
        do_ret();
        // R9: double-fault vector faults -> halt, then requests ignored
        flt_a[0] = VTB + 32'(DFI) * 32'd8;
        do_entry(13, 0, 0, 0, -1, 0);
        for (int k = 0; k < 4; k++) begin
            entry_req = 1'b1; ret_req = 1'b1; entry_idx = 6'd1;
            @(negedge clk);
            chk(busy === 1'b0, "R9 halted busy", 32'(busy), 32'd0);
            chk(mem_req === 1'b0, "R9 halted mem", 32'(mem_req), 32'd0);
            chk(halted === 1'b1, "R9 sticky", 32'(halted), 32'd1);
        end
        entry_req = 1'b0; ret_req = 1'b0;
        do_reset();
        // R9: fault while popping FLAGS on return
        do_entry(2, 0, 0, 0, -1, 0);
        flt_en[1] = 1; flt_a[1] = m_sp + 32'd8;
        do_ret();
        do_reset();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule